// File: doc/BRIEF.md
# Serial Memory Fast-Read Target

This block is the device side of a serial link into a byte-addressed memory, handling one command: a fast read. While chip select is low, the host shifts in an 8-bit opcode, a 24-bit start address and one dummy byte, most significant bit first. Every input bit is sampled on the rising edge of the serial clock. After those 40 clocks the block streams bytes out of the array, most significant bit first, changing the output on falling edges. It steps the address after each byte and wraps from the top of the array to zero, so a single command can read on without end.

The array sits behind a synchronous byte-read port. The block raises a one-cycle read strobe with an address, and the byte is valid after the next rising edge. The next byte is requested while the current one is still shifting out, so there is no gap between bytes. The serial output is modelled as a data bit plus a driver enable, and the pad is high-impedance while the enable is low.

A command with a foreign opcode, or one that arrives while the busy input reports an internal cycle in progress, is ignored until chip select rises. Raising chip select at any moment clears the whole interface and turns the driver off at once.

Top module: `sfr_target`

## Requirements
- R1: A transaction starts with chip select low and is an 8-bit opcode 0x0B, then address bits A23 down to A0, then 8 dummy bits, all sampled on rising edges of the serial clock, most significant bit first.
- R2: The output driver enable stays low for the first 40 rising edges of a transaction, and the first data bit is valid for the host at rising edge 40 (edges counted from 0).
- R3: Data bits change on falling edges, most significant bit of each byte first, and the driver enable stays high for the rest of an accepted transaction.
- R4: The first byte comes from the start address, and each later byte comes from the previous address plus one, with no idle clocks between bytes.
- R5: Address bits at and above MEM_AW are ignored, and after address 2^MEM_AW-1 the read continues at address 0 without a break.
- R6: Any opcode other than 0x0B yields no array reads and no driven output until chip select rises.
- R7: If busy_i is high at rising edge 7 (the last opcode bit), the command is rejected as in R6; busy_i at any other time has no effect.
- R8: Raising chip select at any point, including mid-byte, turns the driver enable off at once, and the next transaction behaves as if from reset.
- R9: Each array read is a one-cycle strobe: the first comes at rising edge 32 and each later one comes 6 rising edges before its byte starts, giving n+1 reads for n complete bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Chip select, active low; high resets the interface |
| sdi_i | input | 1 | Serial data in, sampled on rising edges |
| sdo_o | output | 1 | Serial data out, changes on falling edges |
| sdo_oe_o | output | 1 | Output driver enable; pad is high-impedance when low |
| busy_i | input | 1 | Internal write/erase cycle in progress |
| mem_rd_o | output | 1 | Array read strobe |
| mem_addr_o | output | MEM_AW | Array read address |
| mem_data_i | input | DW | Array read data, valid after the edge that takes the strobe |

## Verification
The bench builds the block with MEM_AW set to 8 and keeps the 24-bit command address and 8-bit bytes at their defaults. The small array lets a read start near the top of memory and cross the wrap within a few bytes, and lets one long burst run through the whole array and past zero in a few thousand clocks. Setting the upper command address bits to non-zero values then shows that they are discarded.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [2:0] {
      PH_OPC = 3'd0,
      PH_ADR = 3'd1,
      PH_DUM = 3'd2,
      PH_DAT = 3'd3,
      PH_IGN = 3'd4
   } phase_t;

   localparam logic [7:0] FAST_RD_OP = 8'h0B;

endpackage

// File: rtl/sfr_cmd_fsm.sv
module sfr_cmd_fsm
   import sfr_pkg::*;
#(
   parameter int unsigned OP_W       = 8,
   parameter logic [OP_W-1:0] OPCODE = FAST_RD_OP,
   parameter int unsigned ADDR_BITS  = 24,
   parameter int unsigned DUMMY_BITS = 8,
   parameter int unsigned DW         = 8
) (
   input  logic   sck_i,
   input  logic   cs_n_i,
   input  logic   sdi_i,
   input  logic   busy_i,
   output phase_t phase_o,
   output logic   addr_shift_o,
   output logic   fetch_o
);

   localparam int unsigned MAXLEN = (ADDR_BITS > DUMMY_BITS) ?
                                    ((ADDR_BITS > OP_W) ? ADDR_BITS : OP_W) :
                                    ((DUMMY_BITS > OP_W) ? DUMMY_BITS : OP_W);
   localparam int unsigned CW   = $clog2(MAXLEN);
   localparam int unsigned DCW  = $clog2(DW);
   localparam logic [CW-1:0] OP_LAST  = CW'(OP_W - 1);
   localparam logic [CW-1:0] AD_LAST  = CW'(ADDR_BITS - 1);
   localparam logic [CW-1:0] DM_LAST  = CW'(DUMMY_BITS - 1);
   // slot inside a byte at which the following byte is requested
   localparam logic [DCW-1:0] PF_SLOT = DCW'(2);

   phase_t          phase_q;
   logic [CW-1:0]   cnt_q;
   logic [DCW-1:0]  dcnt_q;
   logic [OP_W-2:0] opc_q;
   logic [OP_W-1:0] opc_full;

   assign opc_full = {opc_q, sdi_i};

   always_ff @(posedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         phase_q <= PH_OPC;
         cnt_q   <= '0;
         dcnt_q  <= '0;
         opc_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_OPC: begin
               opc_q <= opc_full[OP_W-2:0];
               if (cnt_q == OP_LAST) begin
                  cnt_q   <= '0;
                  phase_q <= ((opc_full == OPCODE) && !busy_i) ? PH_ADR : PH_IGN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_ADR: begin
               if (cnt_q == AD_LAST) begin
                  cnt_q   <= '0;
                  phase_q <= PH_DUM;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DUM: begin
               if (cnt_q == DM_LAST) begin
                  cnt_q   <= '0;
                  dcnt_q  <= '0;
                  phase_q <= PH_DAT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DAT: dcnt_q <= dcnt_q + 1'b1;
            default: phase_q <= PH_IGN;
         endcase
      end
   end

   assign phase_o      = phase_q;
   assign addr_shift_o = (phase_q == PH_ADR);
   assign fetch_o      = ((phase_q == PH_DUM) && (cnt_q == '0)) ||
                         ((phase_q == PH_DAT) && (dcnt_q == PF_SLOT));

endmodule

// File: rtl/sfr_fetch.sv
module sfr_fetch #(
   parameter int unsigned MEM_AW = 24,
   parameter int unsigned DW     = 8
) (
   input  logic              sck_i,
   input  logic              cs_n_i,
   input  logic              sdi_i,
   input  logic              addr_shift_i,
   input  logic              fetch_i,
   input  logic [DW-1:0]     mem_data_i,
   output logic              mem_rd_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic [DW-1:0]     byte_o
);

   logic [MEM_AW-1:0] ptr_q;
   logic              pend_q;
   logic [DW-1:0]     buf_q;

   // Address bits shift through the pointer; bits above MEM_AW fall off the top.
   always_ff @(posedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         ptr_q  <= '0;
         pend_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         if (addr_shift_i) begin
            ptr_q <= {ptr_q[MEM_AW-2:0], sdi_i};
         end else if (fetch_i) begin
            ptr_q <= ptr_q + 1'b1;
         end
         pend_q <= fetch_i;
         if (pend_q) begin
            buf_q <= mem_data_i;
         end
      end
   end

   assign mem_rd_o   = fetch_i;
   assign mem_addr_o = ptr_q;
   assign byte_o     = buf_q;

endmodule

// File: rtl/sfr_out_shift.sv
module sfr_out_shift #(
   parameter int unsigned DW = 8
) (
   input  logic          sck_i,
   input  logic          cs_n_i,
   input  logic          run_i,
   input  logic [DW-1:0] byte_i,
   output logic          sdo_o,
   output logic          sdo_oe_o
);

   localparam int unsigned DCW = $clog2(DW);

   logic [DCW-1:0] idx_q;
   logic [DW-2:0]  shf_q;
   logic           bit_q;
   logic           oe_q;

   always_ff @(negedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         idx_q <= '0;
         shf_q <= '0;
         bit_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (run_i) begin
         oe_q  <= 1'b1;
         idx_q <= idx_q + 1'b1;
         if (idx_q == '0) begin
            bit_q <= byte_i[DW-1];
            shf_q <= byte_i[DW-2:0];
         end else begin
            bit_q <= shf_q[DW-2];
            shf_q <= {shf_q[DW-3:0], 1'b0};
         end
      end
   end

   assign sdo_o    = bit_q;
   assign sdo_oe_o = oe_q;

endmodule

// File: rtl/sfr_target.sv
module sfr_target
   import sfr_pkg::*;
#(
   parameter int unsigned OP_W       = 8,
   parameter logic [OP_W-1:0] OPCODE = FAST_RD_OP,
   parameter int unsigned ADDR_BITS  = 24,
   parameter int unsigned DUMMY_BITS = 8,
   parameter int unsigned MEM_AW     = 24,
   parameter int unsigned DW         = 8
) (
   input  logic              sck_i,
   input  logic              cs_n_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   input  logic              busy_i,
   output logic              mem_rd_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   input  logic [DW-1:0]     mem_data_i
);

   if (MEM_AW < 2 || MEM_AW > ADDR_BITS) begin : g_bad_aw
      $error("sfr_target: MEM_AW must lie in 2..ADDR_BITS");
   end
   if (DW < 4 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("sfr_target: DW must be a power of two of at least 4");
   end
   if (DUMMY_BITS < 2) begin : g_bad_dummy
      $error("sfr_target: DUMMY_BITS must be at least 2 for the first fetch");
   end
   if (OP_W < 2) begin : g_bad_op
      $error("sfr_target: OP_W must be at least 2");
   end

   phase_t        phase;
   logic          addr_shift;
   logic          fetch;
   logic [DW-1:0] cur_byte;

   sfr_cmd_fsm #(
      .OP_W       (OP_W),
      .OPCODE     (OPCODE),
      .ADDR_BITS  (ADDR_BITS),
      .DUMMY_BITS (DUMMY_BITS),
      .DW         (DW)
   ) u_fsm (
      .sck_i        (sck_i),
      .cs_n_i       (cs_n_i),
      .sdi_i        (sdi_i),
      .busy_i       (busy_i),
      .phase_o      (phase),
      .addr_shift_o (addr_shift),
      .fetch_o      (fetch)
   );

   sfr_fetch #(
      .MEM_AW (MEM_AW),
      .DW     (DW)
   ) u_fetch (
      .sck_i        (sck_i),
      .cs_n_i       (cs_n_i),
      .sdi_i        (sdi_i),
      .addr_shift_i (addr_shift),
      .fetch_i      (fetch),
      .mem_data_i   (mem_data_i),
      .mem_rd_o     (mem_rd_o),
      .mem_addr_o   (mem_addr_o),
      .byte_o       (cur_byte)
   );

   sfr_out_shift #(
      .DW (DW)
   ) u_out (
      .sck_i    (sck_i),
      .cs_n_i   (cs_n_i),
      .run_i    (phase == PH_DAT),
      .byte_i   (cur_byte),
      .sdo_o    (sdo_o),
      .sdo_oe_o (sdo_oe_o)
   );

endmodule

// File: rtl/sfr_target_chk.sv
module sfr_target_chk #(
   parameter int unsigned OP_W       = 8,
   parameter logic [OP_W-1:0] OPCODE = 8'h0B,
   parameter int unsigned ADDR_BITS  = 24,
   parameter int unsigned DUMMY_BITS = 8,
   parameter int unsigned MEM_AW     = 24
) (
   input logic              sck_i,
   input logic              cs_n_i,
   input logic              sdi_i,
   input logic              busy_i,
   input logic              sdo_oe_o,
   input logic              mem_rd_o,
   input logic [MEM_AW-1:0] mem_addr_o
);

   localparam int unsigned CMD_BITS = OP_W + ADDR_BITS + DUMMY_BITS;
   localparam int unsigned EW       = $clog2(CMD_BITS + 2) + 1;
   localparam logic [EW-1:0] EMAX   = {EW{1'b1}};

   logic [EW-1:0]     edge_q;
   logic [OP_W-2:0]   opc_q;
   logic              rej_q;
   logic              seen_q;
   logic [MEM_AW-1:0] last_q;

   always_ff @(posedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         edge_q <= '0;
         opc_q  <= '0;
         rej_q  <= 1'b0;
         seen_q <= 1'b0;
         last_q <= '0;
      end else begin
         if (edge_q != EMAX) edge_q <= edge_q + 1'b1;
         if (edge_q < EW'(OP_W)) opc_q <= {opc_q[OP_W-3:0], sdi_i};
         if (edge_q == EW'(OP_W - 1) &&
             (({opc_q, sdi_i} != OPCODE) || busy_i)) rej_q <= 1'b1;
         if (mem_rd_o) begin
            seen_q <= 1'b1;
            last_q <= mem_addr_o;
         end
      end
   end

   // R2
   quiet_cmd_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (edge_q < EW'(CMD_BITS)) |-> !sdo_oe_o);

   // R3
   drive_data_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
      ((edge_q >= EW'(CMD_BITS)) && !rej_q) |-> sdo_oe_o);

   // R6 R7
   reject_quiet_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
      rej_q |-> (!mem_rd_o && !sdo_oe_o));

   // R4 R5
   addr_step_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (mem_rd_o && seen_q) |-> (mem_addr_o == last_q + 1'b1));

   // R9
   rd_pulse_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
      mem_rd_o |=> !mem_rd_o);

   // R9
   first_rd_chk: assert property (@(posedge sck_i) disable iff (cs_n_i)
      ((edge_q == EW'(OP_W + ADDR_BITS)) && !rej_q) |-> mem_rd_o);

endmodule

bind sfr_target sfr_target_chk #(
   .OP_W       (OP_W),
   .OPCODE     (OPCODE),
   .ADDR_BITS  (ADDR_BITS),
   .DUMMY_BITS (DUMMY_BITS),
   .MEM_AW     (MEM_AW)
) u_chk (
   .sck_i      (sck_i),
   .cs_n_i     (cs_n_i),
   .sdi_i      (sdi_i),
   .busy_i     (busy_i),
   .sdo_oe_o   (sdo_oe_o),
   .mem_rd_o   (mem_rd_o),
   .mem_addr_o (mem_addr_o)
);

// File: tb/test_sfr_target.sv
module test_sfr_target;

   localparam int MEM_AW = 8;

   logic              sck = 1'b0;
   logic              cs_n = 1'b1;
   logic              sdi = 1'b0;
   logic              busy = 1'b0;
   logic              sdo;
   logic              sdo_oe;
   logic              mem_rd;
   logic [MEM_AW-1:0] mem_addr;
   logic [7:0]        mem_data = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 sck = ~sck;

   sfr_target #(.MEM_AW(MEM_AW)) i_sfr_target (
      .sck_i      (sck),
      .cs_n_i     (cs_n),
      .sdi_i      (sdi),
      .sdo_o      (sdo),
      .sdo_oe_o   (sdo_oe),
      .busy_i     (busy),
      .mem_rd_o   (mem_rd),
      .mem_addr_o (mem_addr),
      .mem_data_i (mem_data)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 29 + 7) ^ (a >> 2));
   endfunction

   // array model: synchronous read
   always @(posedge sck) if (mem_rd) mem_data <= pat(int'(mem_addr));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard
   logic [7:0] q_exp[$];
   bit         mon_en = 0, cmd_watch = 0, rej_watch = 0;
   bit         cmd_bad = 0, rej_bad = 0, oe_bad = 0;
   int         rd_cnt = 0;
   int         nb = 0;
   logic [7:0] sb = 8'h00;

   always @(posedge sck) begin
      if (!cs_n && mem_rd) rd_cnt++;
      if (cmd_watch && sdo_oe) cmd_bad = 1;
      if (rej_watch && (sdo_oe || mem_rd)) rej_bad = 1;
      if (!mon_en) begin
         nb = 0;
      end else begin
         if (!sdo_oe) oe_bad = 1;
         sb = {sb[6:0], sdo};
         nb++;
         if (nb == 8) begin
            nb = 0;
            if (q_exp.size() == 0) begin
               chk(0, "R4 unexpected byte", int'(sb), 0);
            end else begin
               logic [7:0] e;
               e = q_exp.pop_front();
               // R1 R3 R4 R5: each byte value, MSB first, from consecutive addresses
               chk(sb == e, "R3/R4 data byte", int'(sb), int'(e));
            end
         end
      end
   end

   // driver: one fast-read transaction
   task automatic xfer(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                       input int cut, input bit bsy_op, input bit bsy_late, input bit ok);
      logic [39:0] bits;
      bits = {op, a, 8'h5A};
      cmd_bad = 0; rej_bad = 0; oe_bad = 0;
      @(negedge sck);
      rd_cnt = 0;
      if (ok) for (int k = 0; k < nbytes; k++) q_exp.push_back(pat((int'(a) + k) % (1 << MEM_AW)));
      cs_n = 1'b0;
      cmd_watch = 1;
      rej_watch = !ok;
      for (int i = 0; i < 40; i++) begin
         sdi  = bits[39-i];
         busy = (i < 8) ? bsy_op : bsy_late;
         @(negedge sck);
      end
      cmd_watch = 0;
      mon_en = ok;
      repeat (nbytes * 8 + cut) @(negedge sck);
      cs_n = 1'b1;
      mon_en = 0;
      rej_watch = 0;
      busy = 1'b0;
      #1;
      chk(!cmd_bad, "R2 driver off during command", int'(cmd_bad), 0);
      // R8: driver off at once when chip select rises
      chk(!sdo_oe, "R8 driver off after cs high", int'(sdo_oe), 0);
      if (ok) begin
         chk(!oe_bad, "R3 driver on during data", int'(oe_bad), 0);
         chk(q_exp.size() == 0, "R4 all bytes seen", q_exp.size(), 0);
         // R9: n+1 reads, plus one when the cut passes the prefetch slot
         chk(rd_cnt == nbytes + 1 + ((cut >= 3) ? 1 : 0), "R9 read count",
             rd_cnt, nbytes + 1 + ((cut >= 3) ? 1 : 0));
      end else begin
         chk(!rej_bad, "R6/R7 rejected command silent", int'(rej_bad), 0);
         chk(rd_cnt == 0, "R6/R7 no array reads", rd_cnt, 0);
      end
      q_exp.delete();
   endtask

   initial begin
      repeat (3) @(negedge sck);
      // reset state with chip select high
      chk(sdo_oe == 1'b0, "R8 reset driver off", int'(sdo_oe), 0);
      chk(mem_rd == 1'b0, "R9 reset no read", int'(mem_rd), 0);
      // R1 R4: start at zero
      xfer(8'h0B, 24'h000000, 4, 0, 0, 0, 1);
      // R1 R5: upper address bits discarded
      xfer(8'h0B, 24'h5A3C77, 3, 0, 0, 0, 1);
      // R5: wrap from top to zero
      xfer(8'h0B, 24'hAB12FE, 5, 0, 0, 0, 1);
      // R6: foreign opcode
      xfer(8'h03, 24'h000010, 2, 0, 0, 0, 0);
      // R7: busy at the last opcode bit
      xfer(8'h0B, 24'h000010, 2, 0, 1, 0, 0);
      // R7: busy after the opcode has no effect
      xfer(8'h0B, 24'h000040, 2, 0, 0, 1, 1);
      // R8: cut in the middle of a byte, then a clean transaction
      xfer(8'h0B, 24'h000080, 2, 3, 0, 0, 1);
      xfer(8'h0B, 24'h0000C5, 2, 0, 0, 0, 1);
      // R8: cut early in a byte
      xfer(8'h0B, 24'h000033, 1, 1, 0, 0, 1);
      // R4 R5: long burst through the whole array and past zero
      xfer(8'h0B, 24'hFF00F0, 300, 0, 0, 0, 1);
      repeat (2) @(negedge sck);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge sck);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule